// File: doc/BRIEF.md
# Decode Early Branch Redirect Unit

This block is the decode pipeline stage of a single-thread core. Each cycle it may accept a group of up to `FETCH_W` fetched instructions. It holds them in a bounded queue and hands up to `DEC_W` of them per cycle, in program order, to the rename stage. Each instruction carries its PC, the next PC that fetch predicted, a sequence number, a direct-control flag, an unconditional-control flag, a predicted-taken flag, a conditional-delay-slot flag and a computed branch target.

A direct unconditional branch has a target that is known at decode. When that target disagrees with the predicted next PC, the stage sends a corrected fetch address. Every instruction younger than the squash sequence number is then discarded, both the entries waiting in the queue and the group arriving in the same cycle.

When `DELAY_SLOT` is set, the instruction after the branch is a delay slot. In most cases it still goes to rename, and the redirect fires only after it has left. If the branch was predicted taken and its delay slot is conditional, the redirect fires at once and the slot is dropped.

Top module: `decode_redirect_unit`

## Requirements
- R1: After reset, `status` is Idle (0), `out_valid` and `redirect_valid` are low, both counters are zero and `in_ready` is high.
- R2: Queued instructions leave to rename in sequence order, up to `DEC_W` per cycle, packed from lane 0, and no lane is valid while `rename_stall` is high.
- R3: The queue holds `FETCH_DELAY*FETCH_W+DEC_W` entries. `in_ready` is high exactly when at least `FETCH_W` entries are free, and a group is taken only when `in_ready` is high.
- R4: A misprediction is detected only when an instruction has both the direct flag and the unconditional flag set and its target differs from its predicted PC. `resolved_cnt` adds one for each such direct unconditional instruction that is examined. `mispred_cnt` adds one for each detection.
- R5: On a redirect, `redirect_pc` is the branch target and `redirect_npc` is target+4. Without delay slots, `redirect_taken` is (target != branch PC+4). With delay slots, it is (target != branch PC+8).
- R6: Without delay slots, `redirect_seq` is the branch's sequence number. The branch is the last instruction that reaches rename, and the queue and the incoming group are cleared of every younger entry.
- R7: With delay slots, a mispredicted branch that has both the predicted-taken flag and the conditional-delay-slot flag set redirects in the cycle it leaves, with `redirect_seq` equal to its own sequence number. Its delay slot never reaches rename.
- R8: With delay slots, any other mispredicted branch lets exactly one further instruction (its delay slot) go to rename. The redirect fires in the cycle that slot leaves, with `redirect_seq` equal to the branch's sequence number plus 1. The slot may leave in the same cycle as the branch or in a later cycle.
- R9: `unblock_fetch` is high in a redirect cycle exactly when `status` is Blocked (2) or Unblocking (3), and is never high without a redirect.
- R10: `status` changes only at clock edges, according to these rules:
  - It becomes Squashing (4) in the cycle after a redirect.
  - Otherwise, if instructions were left undecoded, it becomes Blocked (2). It becomes Unblocking (3) instead when the stage was already Blocked or Unblocking and rename is not stalled.
  - Otherwise, it becomes Running (1) if anything was accepted or emitted, and Idle (0) if not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rename_stall | input | 1 | Rename cannot take instructions this cycle |
| in_valid | input | FETCH_W | Valid flag of each incoming slot, filled from slot 0 |
| in_pc | input | FETCH_W*32 | PC of each slot |
| in_pred_pc | input | FETCH_W*32 | Predicted next PC of each slot |
| in_target | input | FETCH_W*32 | Computed branch target of each slot |
| in_seq | input | FETCH_W*16 | Sequence number of each slot |
| in_direct | input | FETCH_W | Slot is a direct control instruction |
| in_uncond | input | FETCH_W | Slot is an unconditional control instruction |
| in_pred_taken | input | FETCH_W | Slot was predicted taken |
| in_cond_dslot | input | FETCH_W | Slot's delay slot is conditional |
| in_ready | output | 1 | A full group can be accepted |
| out_valid | output | DEC_W | Lane carries an instruction to rename |
| out_pc | output | DEC_W*32 | PC per lane |
| out_seq | output | DEC_W*16 | Sequence number per lane |
| redirect_valid | output | 1 | Redirect and squash this cycle |
| redirect_pc | output | 32 | Corrected next PC |
| redirect_npc | output | 32 | Corrected next-next PC |
| redirect_taken | output | 1 | Branch-taken indication to fetch |
| redirect_seq | output | 16 | Squash sequence number; younger entries are dropped |
| unblock_fetch | output | 1 | Tells fetch to resume after a blocked period |
| status | output | 3 | Stage state, encoded 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing |
| resolved_cnt | output | CNT_W | Count of direct unconditional instructions examined |
| mispred_cnt | output | CNT_W | Count of detected mispredictions |

## Verification
An accepted group reaches the queue head one clock edge after acceptance. The head lanes and any redirect are combinational outputs in that same cycle, and `status` and both counters take their new values one edge after the cycle that caused them. The bench drives on the falling edge and samples 1 ns later. It checks each emitted sequence number against the next entry of its expected prefix, regardless of how stalls spread the instructions over cycles. It checks redirect fields in the redirect cycle itself, and checks Squashing in exactly the next sample.

// File: rtl/decode_redirect_pkg.sv
package decode_redirect_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEQ_W      = 16;
  localparam int INST_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCK   = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4
  } dstat_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pred_pc;
    logic [ADDR_W-1:0] target;
    logic [SEQ_W-1:0]  seq;
    logic              direct;
    logic              uncond;
    logic              pred_taken;
    logic              cond_dslot;
  } inst_t;

  function automatic logic is_resolvable(inst_t i);
    return i.direct && i.uncond;
  endfunction

  function automatic logic is_mispred(inst_t i);
    return is_resolvable(i) && (i.target != i.pred_pc);
  endfunction

  function automatic logic [ADDR_W-1:0] next_inst(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(INST_BYTES);
  endfunction

  function automatic logic taken_flag(inst_t i, bit ds);
    logic [ADDR_W-1:0] step;
    step = ds ? ADDR_W'(2 * INST_BYTES) : ADDR_W'(INST_BYTES);
    return i.target != (i.pc + step);
  endfunction
endpackage

// File: rtl/decode_skid_queue.sv
module decode_skid_queue
  import decode_redirect_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int FETCH_W    = 2,
  parameter int DEC_W      = 2,
  parameter bit DELAY_SLOT = 1'b0,
  localparam int QCW = $clog2(DEPTH + 1),
  localparam int ECW = $clog2(DEC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [FETCH_W-1:0] push_valid,
  input  inst_t             push_inst [FETCH_W],
  input  logic [ECW-1:0]    pop_n,
  input  logic              squash,
  input  logic [SEQ_W-1:0]  sq_seq,
  output inst_t             head [DEC_W],
  output logic [QCW-1:0]    count
);
  inst_t          mem_q [DEPTH];
  inst_t          mem_d [DEPTH];
  inst_t          shifted [DEPTH];
  logic [QCW-1:0] cnt_q;
  logic [QCW-1:0] cnt_d;
  int             n_live;
  int             n_drop;
  logic           scan_on;

  always_comb begin
    n_live  = int'(cnt_q) - int'(pop_n);
    n_drop  = 0;
    scan_on = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      shifted[i] = (i + int'(pop_n) < DEPTH) ? mem_q[i + int'(pop_n)] : '0;
    if (squash) begin
      if (DELAY_SLOT) begin
        // pop from the oldest end while younger than the squash point
        scan_on = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
          if (scan_on && i < n_live && shifted[i].seq > sq_seq) n_drop++;
          else scan_on = 1'b0;
        end
      end else begin
        n_drop = n_live;
      end
    end
    for (int i = 0; i < DEPTH; i++)
      mem_d[i] = (i + n_drop < DEPTH) ? shifted[i + n_drop] : '0;
    n_live = n_live - n_drop;
    for (int j = 0; j < FETCH_W; j++) begin
      if (push_en && push_valid[j] && !(squash && push_inst[j].seq > sq_seq)
          && n_live < DEPTH) begin
        mem_d[n_live] = push_inst[j];
        n_live++;
      end
    end
    cnt_d = QCW'(n_live);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      mem_q <= mem_d;
    end
  end

  for (genvar k = 0; k < DEC_W; k++) begin : g_head
    assign head[k] = mem_q[k];
  end
  assign count = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (int'(cnt_q) + FETCH_W <= DEPTH));

  if (!DELAY_SLOT) begin : g_drain_chk
    // R6
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (cnt_q == '0));
  end
endmodule

// File: rtl/decode_redirect_ctrl.sv
module decode_redirect_ctrl
  import decode_redirect_pkg::*;
#(
  parameter int DEC_W      = 2,
  parameter bit DELAY_SLOT = 1'b0,
  localparam int ECW = $clog2(DEC_W + 1)
) (
  input  inst_t            head [DEC_W],
  input  logic [ECW-1:0]   avail,
  input  logic             pend_valid,
  input  inst_t            pend_inst,
  output logic [ECW-1:0]   emit_n,
  output logic [ECW-1:0]   res_inc,
  output logic             mp_hit,
  output logic             squash,
  output logic [SEQ_W-1:0] sq_seq,
  output inst_t            src,
  output logic             set_pend
);
  logic [DEC_W-1:0] lane_res;
  logic [DEC_W-1:0] lane_mp;
  int   emit_i;
  int   res_i;
  logic found;

  for (genvar k = 0; k < DEC_W; k++) begin : g_lane
    assign lane_res[k] = is_resolvable(head[k]) && (k < int'(avail));
    assign lane_mp[k]  = is_mispred(head[k]) && (k < int'(avail));
  end

  always_comb begin
    emit_i   = int'(avail);
    res_i    = 0;
    found    = 1'b0;
    mp_hit   = 1'b0;
    squash   = 1'b0;
    sq_seq   = '0;
    src      = head[0];
    set_pend = 1'b0;
    if (pend_valid) begin
      // waiting branch: release its delay slot, then squash behind it
      src = pend_inst;
      if (avail != '0) begin
        emit_i = 1;
        squash = 1'b1;
        sq_seq = pend_inst.seq + SEQ_W'(1);
      end
    end else begin
      for (int k = 0; k < DEC_W; k++) begin
        if (!found) begin
          if (lane_res[k]) res_i++;
          if (lane_mp[k]) begin
            found  = 1'b1;
            mp_hit = 1'b1;
            src    = head[k];
            if (!DELAY_SLOT || (head[k].pred_taken && head[k].cond_dslot)) begin
              squash = 1'b1;
              sq_seq = head[k].seq;
              emit_i = k + 1;
            end else if (k + 1 < int'(avail)) begin
              squash = 1'b1;
              sq_seq = head[k].seq + SEQ_W'(1);
              emit_i = k + 2;
            end else begin
              set_pend = 1'b1;
              emit_i   = k + 1;
            end
          end
        end
      end
    end
    emit_n  = ECW'(emit_i);
    res_inc = ECW'(res_i);
  end
endmodule

// File: rtl/decode_status_fsm.sv
module decode_status_fsm
  import decode_redirect_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   squash,
  input  logic   leftover,
  input  logic   stall,
  input  logic   active,
  output dstat_e status
);
  dstat_e st_q;
  dstat_e st_d;

  always_comb begin
    if (squash)
      st_d = ST_SQUASH;
    else if (leftover)
      st_d = (!stall && (st_q == ST_BLOCK || st_q == ST_UNBLOCK)) ? ST_UNBLOCK : ST_BLOCK;
    else if (active)
      st_d = ST_RUN;
    else
      st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign status = st_q;

  // R10
  unblock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UNBLOCK) |-> ($past(st_q) == ST_BLOCK || $past(st_q) == ST_UNBLOCK));
endmodule

// File: rtl/decode_redirect_unit.sv
module decode_redirect_unit
  import decode_redirect_pkg::*;
#(
  parameter int FETCH_W     = 2,
  parameter int DEC_W       = 2,
  parameter int FETCH_DELAY = 1,
  parameter bit DELAY_SLOT  = 1'b0,
  parameter int CNT_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rename_stall,
  input  logic [FETCH_W-1:0]        in_valid,
  input  logic [FETCH_W*ADDR_W-1:0] in_pc,
  input  logic [FETCH_W*ADDR_W-1:0] in_pred_pc,
  input  logic [FETCH_W*ADDR_W-1:0] in_target,
  input  logic [FETCH_W*SEQ_W-1:0]  in_seq,
  input  logic [FETCH_W-1:0]        in_direct,
  input  logic [FETCH_W-1:0]        in_uncond,
  input  logic [FETCH_W-1:0]        in_pred_taken,
  input  logic [FETCH_W-1:0]        in_cond_dslot,
  output logic                      in_ready,
  output logic [DEC_W-1:0]          out_valid,
  output logic [DEC_W*ADDR_W-1:0]   out_pc,
  output logic [DEC_W*SEQ_W-1:0]    out_seq,
  output logic                      redirect_valid,
  output logic [ADDR_W-1:0]         redirect_pc,
  output logic [ADDR_W-1:0]         redirect_npc,
  output logic                      redirect_taken,
  output logic [SEQ_W-1:0]          redirect_seq,
  output logic                      unblock_fetch,
  output logic [2:0]                status,
  output logic [CNT_W-1:0]          resolved_cnt,
  output logic [CNT_W-1:0]          mispred_cnt
);
  localparam int DEPTH = FETCH_DELAY * FETCH_W + DEC_W;
  localparam int QCW   = $clog2(DEPTH + 1);
  localparam int ECW   = $clog2(DEC_W + 1);

  inst_t            push_inst [FETCH_W];
  inst_t            head [DEC_W];
  inst_t            src;
  inst_t            pend_inst_q;
  logic             pend_q;
  logic [QCW-1:0]   q_cnt;
  logic [ECW-1:0]   avail;
  logic [ECW-1:0]   emit_n;
  logic [ECW-1:0]   res_inc;
  logic             mp_hit;
  logic             squash;
  logic [SEQ_W-1:0] sq_seq;
  logic             set_pend;
  logic             push_en;
  logic             leftover;
  logic             active;
  dstat_e           st;
  logic [CNT_W-1:0] res_q;
  logic [CNT_W-1:0] mis_q;

  for (genvar j = 0; j < FETCH_W; j++) begin : g_unpack
    assign push_inst[j] = '{
      pc:         in_pc[j*ADDR_W +: ADDR_W],
      pred_pc:    in_pred_pc[j*ADDR_W +: ADDR_W],
      target:     in_target[j*ADDR_W +: ADDR_W],
      seq:        in_seq[j*SEQ_W +: SEQ_W],
      direct:     in_direct[j],
      uncond:     in_uncond[j],
      pred_taken: in_pred_taken[j],
      cond_dslot: in_cond_dslot[j]
    };
  end

  assign in_ready = (int'(q_cnt) + FETCH_W <= DEPTH);
  assign push_en  = in_ready && (in_valid != '0);
  assign avail    = rename_stall ? '0 :
                    ((int'(q_cnt) >= DEC_W) ? ECW'(DEC_W) : ECW'(q_cnt));

  decode_skid_queue #(
    .DEPTH(DEPTH), .FETCH_W(FETCH_W), .DEC_W(DEC_W), .DELAY_SLOT(DELAY_SLOT)
  ) i_queue (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_valid(in_valid),
    .push_inst(push_inst), .pop_n(emit_n), .squash(squash), .sq_seq(sq_seq),
    .head(head), .count(q_cnt)
  );

  decode_redirect_ctrl #(.DEC_W(DEC_W), .DELAY_SLOT(DELAY_SLOT)) i_ctrl (
    .head(head), .avail(avail), .pend_valid(pend_q), .pend_inst(pend_inst_q),
    .emit_n(emit_n), .res_inc(res_inc), .mp_hit(mp_hit), .squash(squash),
    .sq_seq(sq_seq), .src(src), .set_pend(set_pend)
  );

  assign leftover = int'(q_cnt) > int'(emit_n);
  assign active   = (emit_n != '0) || push_en;

  decode_status_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .squash(squash), .leftover(leftover),
    .stall(rename_stall), .active(active), .status(st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_inst_q <= '0;
      res_q       <= '0;
      mis_q       <= '0;
    end else begin
      if (set_pend) begin
        pend_q      <= 1'b1;
        pend_inst_q <= src;
      end else if (squash) begin
        pend_q <= 1'b0;
      end
      res_q <= res_q + CNT_W'(res_inc);
      mis_q <= mis_q + CNT_W'(mp_hit);
    end
  end

  for (genvar k = 0; k < DEC_W; k++) begin : g_pack
    assign out_valid[k]              = k < int'(emit_n);
    assign out_pc[k*ADDR_W +: ADDR_W] = head[k].pc;
    assign out_seq[k*SEQ_W +: SEQ_W]  = head[k].seq;
  end

  assign redirect_valid = squash;
  assign redirect_pc    = src.target;
  assign redirect_npc   = next_inst(src.target);
  assign redirect_taken = taken_flag(src, DELAY_SLOT);
  assign redirect_seq   = sq_seq;
  assign unblock_fetch  = squash && (st == ST_BLOCK || st == ST_UNBLOCK);
  assign status         = st;
  assign resolved_cnt   = res_q;
  assign mispred_cnt    = mis_q;

  // R10
  squash_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (status == 3'd4));
  // R9
  unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_fetch |-> redirect_valid);
  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_stall |-> (out_valid == '0));
  // R4
  mispred_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mispred_cnt != $past(mispred_cnt)) |-> (mispred_cnt == $past(mispred_cnt) + 1'b1));
  // R8
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rename_stall && q_cnt != '0) |-> redirect_valid);
endmodule

// File: tb/test_decode_redirect_unit.sv
module test_decode_redirect_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mode = 1'b0;

  logic        stall = 1'b0;
  logic [1:0]  drv_valid = '0;
  logic [63:0] d_pc = '0, d_pred = '0, d_tgt = '0;
  logic [31:0] d_seq = '0;
  logic [1:0]  d_dir = '0, d_unc = '0, d_pt = '0, d_cd = '0;

  logic        rdy [2];
  logic [1:0]  ov [2];
  logic [63:0] opc [2];
  logic [31:0] oseq [2];
  logic        rv [2], rtk [2], ub [2];
  logic [31:0] rpc [2], rnpc [2];
  logic [15:0] rseq [2], rcnt [2], mcnt [2];
  logic [2:0]  sts [2];

  decode_redirect_unit #(.DELAY_SLOT(1'b0)) i_decode_redirect_unit (
    .clk(clk), .rst_n(rst_n), .rename_stall(stall),
    .in_valid(mode ? 2'b00 : drv_valid), .in_pc(d_pc), .in_pred_pc(d_pred),
    .in_target(d_tgt), .in_seq(d_seq), .in_direct(d_dir), .in_uncond(d_unc),
    .in_pred_taken(d_pt), .in_cond_dslot(d_cd), .in_ready(rdy[0]),
    .out_valid(ov[0]), .out_pc(opc[0]), .out_seq(oseq[0]),
    .redirect_valid(rv[0]), .redirect_pc(rpc[0]), .redirect_npc(rnpc[0]),
    .redirect_taken(rtk[0]), .redirect_seq(rseq[0]), .unblock_fetch(ub[0]),
    .status(sts[0]), .resolved_cnt(rcnt[0]), .mispred_cnt(mcnt[0]));

  decode_redirect_unit #(.DELAY_SLOT(1'b1)) i_decode_redirect_unit_ds (
    .clk(clk), .rst_n(rst_n), .rename_stall(stall),
    .in_valid(mode ? drv_valid : 2'b00), .in_pc(d_pc), .in_pred_pc(d_pred),
    .in_target(d_tgt), .in_seq(d_seq), .in_direct(d_dir), .in_uncond(d_unc),
    .in_pred_taken(d_pt), .in_cond_dslot(d_cd), .in_ready(rdy[1]),
    .out_valid(ov[1]), .out_pc(opc[1]), .out_seq(oseq[1]),
    .redirect_valid(rv[1]), .redirect_pc(rpc[1]), .redirect_npc(rnpc[1]),
    .redirect_taken(rtk[1]), .redirect_seq(rseq[1]), .unblock_fetch(ub[1]),
    .status(sts[1]), .resolved_cnt(rcnt[1]), .mispred_cnt(mcnt[1]));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stream storage
  logic [31:0] s_pc [8], s_pred [8], s_tgt [8];
  logic [15:0] s_seq [8];
  logic        s_dir [8], s_unc [8], s_pt [8], s_cd [8];
  int exp_res [2] = '{0, 0};
  int exp_mis [2] = '{0, 0};
  int seq_base = 16;

  task automatic drive_from(input int idx, input int n);
    drv_valid = '0;
    for (int l = 0; l < 2; l++) begin
      if (idx + l < n) begin
        drv_valid[l]        = 1'b1;
        d_pc[l*32 +: 32]    = s_pc[idx+l];
        d_pred[l*32 +: 32]  = s_pred[idx+l];
        d_tgt[l*32 +: 32]   = s_tgt[idx+l];
        d_seq[l*16 +: 16]   = s_seq[idx+l];
        d_dir[l] = s_dir[idx+l]; d_unc[l] = s_unc[idx+l];
        d_pt[l]  = s_pt[idx+l];  d_cd[l]  = s_cd[idx+l];
      end
    end
  endtask

  function automatic bit stall_pat(input int p, input int c);
    case (p)
      1: return (c % 3) == 2;
      2: return (c % 5) < 3;
      3: return ((c * 7) % 4) == 1;
      default: return 1'b0;
    endcase
  endfunction

  // b: branch index, mis: mispredicted, pt/cd: flags, kind: target shape, pat: stall pattern
  task automatic run_stream(input int b, input bit mis, input bit pt, input bit cd,
                            input int kind, input int pat);
    int n = 8, exp_n, idx = 0, got = 0, cyc = 0, quiet = 0;
    bit redirected = 0, chk_sq = 0, stop = 0;
    logic [31:0] base = 32'h1000 + 32'(seq_base) * 32'h100;
    for (int i = 0; i < n; i++) begin
      s_pc[i] = base + 32'(4*i); s_pred[i] = s_pc[i] + 4; s_tgt[i] = 32'h0;
      s_seq[i] = 16'(seq_base + i);
      s_dir[i] = 0; s_unc[i] = 0; s_pt[i] = 0; s_cd[i] = 0;
    end
    // R4 decoys: conditional direct and indirect unconditional with wrong targets
    s_dir[7] = 1; s_tgt[7] = 32'h9000;
    s_unc[6] = 1; s_tgt[6] = 32'h9100;
    s_dir[b] = 1; s_unc[b] = 1; s_pt[b] = pt; s_cd[b] = cd;
    s_tgt[b] = (kind == 0) ? s_pc[b] + 32'h40 : (kind == 1) ? s_pc[b] + 8 : s_pc[b] + 4;
    if (mis) s_pred[b] = (s_tgt[b] == s_pc[b] + 4) ? s_pc[b] + 32'h100 : s_pc[b] + 4;
    else     s_pred[b] = s_tgt[b];
    if (!mis) exp_n = n;
    else if (!mode || (pt && cd)) exp_n = b + 1;
    else exp_n = b + 2;
    exp_res[mode] += 1;
    exp_mis[mode] += mis ? 1 : 0;
    while (!stop) begin
      @(negedge clk);
      stall = stall_pat(pat, cyc);
      if (!redirected && idx < n && rdy[mode]) begin
        drive_from(idx, n);
        idx += 2;
      end else drv_valid = '0;
      #1;
      if (chk_sq) begin
        chk(sts[mode] == 3'd4, "R10 squashing after redirect", sts[mode], 4);
        chk_sq = 0;
      end
      if (ov[mode] != 0) quiet = 0; else quiet++;
      for (int l = 0; l < 2; l++) begin
        if (ov[mode][l]) begin
          if (got < exp_n)
            chk(oseq[mode][l*16 +: 16] == s_seq[got] && opc[mode][l*32 +: 32] == s_pc[got],
                mode ? "R8 R2 rename order" : "R6 R2 rename order",
                oseq[mode][l*16 +: 16], s_seq[got]);
          else
            chk(0, mode ? "R7 R8 extra instruction after squash" : "R6 extra instruction after squash",
                oseq[mode][l*16 +: 16], 0);
          got++;
        end
      end
      if (rv[mode]) begin
        chk(mis && !redirected, "R4 redirect only on mispredict", rv[mode], mis);
        chk(rpc[mode] == s_tgt[b] && rnpc[mode] == s_tgt[b] + 4, "R5 redirect pcs",
            {rpc[mode], rnpc[mode]}, {s_tgt[b], s_tgt[b] + 32'd4});
        chk(rtk[mode] == (mode ? (s_tgt[b] != s_pc[b] + 8) : (s_tgt[b] != s_pc[b] + 4)),
            "R5 taken flag", rtk[mode], 0);
        chk(rseq[mode] == ((!mode || (pt && cd)) ? s_seq[b] : s_seq[b] + 1),
            mode ? (pt && cd ? "R7 squash seq" : "R8 squash seq") : "R6 squash seq",
            rseq[mode], s_seq[b]);
        chk(ub[mode] == (sts[mode] == 3'd2 || sts[mode] == 3'd3), "R9 unblock", ub[mode], 0);
        chk(got == exp_n, "R8 R7 R6 squash fires with last survivor", got, exp_n);
        redirected = 1; chk_sq = 1;
      end else if (ub[mode]) chk(0, "R9 unblock without redirect", 1, 0);
      cyc++;
      if (((idx >= n) || redirected) && quiet >= 6 && !chk_sq) stop = 1;
      if (cyc > 150) stop = 1;
    end
    drv_valid = '0; stall = 0;
    chk(got == exp_n, "R6 R7 R8 survivor count", got, exp_n);
    chk(redirected == mis, "R4 redirect presence", redirected, mis);
    @(negedge clk); #1;
    chk(rcnt[mode] == 16'(exp_res[mode]), "R4 resolved count", rcnt[mode], exp_res[mode]);
    chk(mcnt[mode] == 16'(exp_mis[mode]), "R4 mispredict count", mcnt[mode], exp_mis[mode]);
    seq_base += 16;
  endtask

  task automatic load_plain(input int n);
    for (int i = 0; i < n; i++) begin
      s_pc[i] = 32'h200 + 32'(4*i); s_pred[i] = s_pc[i] + 4; s_tgt[i] = 0;
      s_seq[i] = 16'(seq_base + i);
      s_dir[i] = 0; s_unc[i] = 0; s_pt[i] = 0; s_cd[i] = 0;
    end
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(sts[m] == 3'd0, "R1 idle status", sts[m], 0);
      chk(ov[m] == 2'b00 && !rv[m], "R1 no outputs", {ov[m], rv[m]}, 0);
      chk(rcnt[m] == 0 && mcnt[m] == 0, "R1 counters clear", {rcnt[m], mcnt[m]}, 0);
      chk(rdy[m] == 1'b1, "R1 ready", rdy[m], 1);
    end

    // directed fill/stall/unblock sequence on the plain instance
    mode = 0;
    load_plain(4);
    @(negedge clk); stall = 1; drive_from(0, 4);
    @(negedge clk); drive_from(2, 4); #1;
    chk(rdy[0] == 1'b1, "R3 ready with two free", rdy[0], 1);
    chk(ov[0] == 2'b00, "R2 stalled lanes quiet", ov[0], 0);
    chk(sts[0] == 3'd1, "R10 running after accept", sts[0], 1);
    @(negedge clk); drv_valid = '0; #1;
    chk(rdy[0] == 1'b0, "R3 not ready when full", rdy[0], 0);
    chk(sts[0] == 3'd2, "R10 blocked", sts[0], 2);
    chk(ov[0] == 2'b00, "R2 stalled lanes quiet", ov[0], 0);
    stall = 0; #1;
    chk(ov[0] == 2'b11 && oseq[0] == {s_seq[1], s_seq[0]}, "R2 first pair",
        oseq[0], {s_seq[1], s_seq[0]});
    @(negedge clk); #1;
    chk(sts[0] == 3'd3, "R10 unblocking", sts[0], 3);
    chk(ov[0] == 2'b11 && oseq[0] == {s_seq[3], s_seq[2]}, "R2 second pair",
        oseq[0], {s_seq[3], s_seq[2]});
    @(negedge clk); #1;
    chk(sts[0] == 3'd1 && ov[0] == 2'b00, "R10 running after drain", sts[0], 1);
    @(negedge clk); #1;
    chk(sts[0] == 3'd0, "R10 idle", sts[0], 0);
    seq_base += 16;

    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int b = 0; b < 6; b++)
        for (int pat = 0; pat < 4; pat++)
          for (int kind = 0; kind < 3; kind++) begin
            if (m == 0) begin
              run_stream(b, 0, 0, 0, kind, pat);
              run_stream(b, 1, kind == 1, 1, kind, pat);
            end else begin
              run_stream(b, 0, 1, 1, kind, pat);
              run_stream(b, 1, 0, 0, kind, pat);
              run_stream(b, 1, 1, 1, kind, pat);
              run_stream(b, 1, 1, 0, kind, pat);
              run_stream(b, 1, 0, 1, kind, pat);
            end
          end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule